// File: doc/BRIEF.md
# Accumulator Execution Unit with Memory-Destination Mode

This unit runs the data instructions of an 8-bit one-operand machine. It holds an accumulator, an X index register and an 8-bit status register, and it reaches a zero-page memory through a single synchronous port. An instruction arrives as a 4-bit operation code and an 8-bit zero-page address. In the default mode the unit reads the addressed byte, combines it with the accumulator and keeps the result in the accumulator. Increment and decrement work on memory directly as read-modify-write sequences that cannot be broken up.

When status bit 5 is set, the logic, arithmetic, compare and load operations treat the zero-page byte whose address is held in X as their accumulator. That byte is the left operand, and except for compare it also receives the result. Each class of operation spends a fixed number of extra cycles in this mode. The store, X-load, accumulator-shift and flag operations behave the same in both modes.

The memory is synchronous. Read data appears one cycle after its address is driven, and the port carries one access per clock. A controller pulses `start` while `busy` is low. `done` then reports completion.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, the accumulator, X and status are all 0, and `busy`, `done` and `mem_we` are low.
- R2: Operation codes are LDA=0, ORA=1, AND=2, EOR=3, ADC=4, SBC=5, CMP=6, STA=7, LDX=8, INC=9, DEC=A, ASL=B, SET-MODE=C, CLEAR-MODE=D, SEC=E and CLC=F. With bit 5 clear, LDA, ORA, AND, EOR, ADC and SBC keep `busy` high for 3 cycles. They read the addressed byte once, and the accumulator takes the operand, OR, AND, XOR, sum or difference.
- R3: ADC adds the operand and the carry, and C becomes the carry out. SBC computes left − operand − (1 − C), and C becomes 1 when no borrow occurs. CMP computes left − operand without storing it, and C becomes 1 when left ≥ operand.
- R4: Status bit 7 (N) takes bit 7 of every result, and status bit 1 (Z) is set when the result is zero. Status bit 0 (C) changes only on ADC, SBC, CMP, ASL, SEC and CLC.
- R5: STA keeps `busy` high for 1 cycle and writes the accumulator to the addressed byte. It is the only operation that does not use an RMW sequence and still writes memory.
- R6: With status bit 5 set, ORA, AND, EOR, ADC, SBC, CMP and LDA use mem[X] as the left operand. Except for CMP, they write the result to mem[X], leave the accumulator unchanged, and set N and Z from the written value.
- R7: With bit 5 set, CMP takes 4 busy cycles, LDA takes 5, and ORA, AND, EOR, ADC and SBC take 6.
- R8: With bit 5 set, STA, LDX and ASL behave exactly as they do with bit 5 clear. They use the accumulator, X or the operand address and never touch mem[X].
- R9: INC and DEC take 5 busy cycles. They write twice to the same address, first the old value and then the value ±1.
- R10: `start` is accepted only while `busy` is low and is ignored otherwise. `done` is high for exactly one cycle after the last busy cycle, and the results are visible in that cycle.
- R11: ASL shifts the accumulator left with C taking the old bit 7. SET-MODE and CLEAR-MODE write status bit 5, and SEC and CLC write C. Each of these four, like ASL, takes 1 busy cycle and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op_code | input | 4 | Operation code, sampled when start is accepted |
| op_addr | input | 8 | Zero-page operand address, sampled when start is accepted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc | output | 8 | Accumulator |
| xidx | output | 8 | X index register |
| status | output | 8 | Status: bit 7 N, bit 5 mode, bit 1 Z, bit 0 C |
| mem_addr | output | 8 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |

## Verification
The memory-destination paths are the hardest to reach from the ports. Reaching them takes three preparatory steps: X must first be loaded through LDX from a seeded byte, the mode must be switched on by its own operation, and the byte at X must be preloaded in the bench memory. The directed sequence performs these steps and then runs the logic, add, compare and load operations against that byte. It checks the memory contents, the cycle count and the untouched accumulator for each one. A second `start` pulse is issued in the middle of an increment, with an operation that would visibly change the accumulator, to show that a busy RMW sequence cannot be disturbed.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  parameter int DW = 8;
  parameter int SW = 8;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_T = 5;
  localparam int FLAG_N = 7;
  localparam logic [DW-1:0] ONE = 1;

  typedef enum logic [3:0] {
    OP_LDA = 4'h0, OP_ORA = 4'h1, OP_AND = 4'h2, OP_EOR = 4'h3,
    OP_ADC = 4'h4, OP_SBC = 4'h5, OP_CMP = 4'h6, OP_STA = 4'h7,
    OP_LDX = 4'h8, OP_INC = 4'h9, OP_DEC = 4'hA, OP_ASL = 4'hB,
    OP_SEM = 4'hC, OP_CLM = 4'hD, OP_SEC = 4'hE, OP_CLC = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_DATA, ST_PTR, ST_PTRD, ST_EXEC, ST_WBOLD, ST_WB
  } st_e;

  typedef struct packed {
    logic [DW-1:0] val;
    logic          cout;
  } alu_out_t;

  function automatic logic mode_sensitive(op_e op);
    return op <= OP_CMP;
  endfunction

  function automatic logic is_modify(op_e op);
    return (op >= OP_ORA) && (op <= OP_SBC);
  endfunction

  function automatic logic is_rmw(op_e op);
    return (op == OP_INC) || (op == OP_DEC);
  endfunction

  function automatic logic is_implied(op_e op);
    return op >= OP_ASL;
  endfunction

  function automatic logic sets_carry(op_e op);
    return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_ASL);
  endfunction

  function automatic alu_out_t alu_eval(op_e op, logic [DW-1:0] l,
                                        logic [DW-1:0] r, logic cin);
    alu_out_t o;
    logic [DW:0] s;
    o.val  = r;
    o.cout = cin;
    s      = '0;
    case (op)
      OP_ORA: o.val = l | r;
      OP_AND: o.val = l & r;
      OP_EOR: o.val = l ^ r;
      OP_ADC: begin
        s = {1'b0, l} + {1'b0, r} + {{DW{1'b0}}, cin};
        o.val = s[DW-1:0]; o.cout = s[DW];
      end
      OP_SBC: begin
        s = {1'b0, l} + {1'b0, ~r} + {{DW{1'b0}}, cin};
        o.val = s[DW-1:0]; o.cout = s[DW];
      end
      OP_CMP: begin
        s = {1'b0, l} + {1'b0, ~r} + {{DW{1'b0}}, 1'b1};
        o.val = s[DW-1:0]; o.cout = s[DW];
      end
      OP_INC: o.val = r + ONE;
      OP_DEC: o.val = r - ONE;
      OP_ASL: begin
        o.val = {l[DW-2:0], 1'b0}; o.cout = l[DW-1];
      end
      default: ;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] left,
  input  logic [DW-1:0] right,
  input  logic          cin,
  output logic [DW-1:0] val,
  output logic          cout
);
  alu_out_t r;
  always_comb begin
    r    = alu_eval(op, left, right, cin);
    val  = r.val;
    cout = r.cout;
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_exec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  op_in,
  input  op_e  op_q,
  input  logic use_mem,
  output st_e  state,
  output logic accept,
  output logic done
);
  st_e nxt;

  assign accept = start && (state == ST_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start) nxt = is_implied(op_in) ? ST_EXEC : ST_ISSUE;
      ST_ISSUE: nxt = (op_q == OP_STA) ? ST_IDLE : ST_DATA;
      ST_DATA:  nxt = use_mem ? ST_PTR : ST_EXEC;
      ST_PTR:   nxt = is_modify(op_q) ? ST_PTRD : ST_EXEC;
      ST_PTRD:  nxt = ST_EXEC;
      ST_EXEC:  begin
        if (is_rmw(op_q))                       nxt = ST_WBOLD;
        else if (use_mem && op_q != OP_CMP)     nxt = ST_WB;
        else                                    nxt = ST_IDLE;
      end
      ST_WBOLD: nxt = ST_WB;
      ST_WB:    nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state != ST_IDLE) && (nxt == ST_IDLE);
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state != ST_IDLE));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE || $past(state) == ST_IDLE));
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op_code,
  input  logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] xidx,
  output logic [SW-1:0] status,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  st_e           st;
  logic          accept;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic          mode_q;
  logic [DW-1:0] acc_q, x_q, opnd_q, tmp_q, res_q;
  logic [SW-1:0] p_q;
  logic          use_mem;
  logic [DW-1:0] alu_left, alu_val;
  logic          alu_c;
  logic [AW-1:0] x_addr;

  assign use_mem = mode_q && mode_sensitive(op_q);
  assign x_addr  = AW'(x_q);

  acc_seq u_seq (
    .clk, .rst_n, .start,
    .op_in   (op_e'(op_code)),
    .op_q,
    .use_mem,
    .state   (st),
    .accept,
    .done
  );

  always_comb begin
    if (!use_mem)              alu_left = acc_q;
    else if (op_q == OP_CMP)   alu_left = mem_rdata;
    else                       alu_left = tmp_q;
  end

  acc_alu u_alu (
    .op    (op_q),
    .left  (alu_left),
    .right (opnd_q),
    .cin   (p_q[FLAG_C]),
    .val   (alu_val),
    .cout  (alu_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_LDA;
      addr_q <= '0;
      mode_q <= 1'b0;
      acc_q  <= '0;
      x_q    <= '0;
      opnd_q <= '0;
      tmp_q  <= '0;
      res_q  <= '0;
      p_q    <= '0;
    end else begin
      if (accept) begin
        op_q   <= op_e'(op_code);
        addr_q <= op_addr;
        mode_q <= p_q[FLAG_T];
      end
      if (st == ST_DATA) opnd_q <= mem_rdata;
      if (st == ST_PTRD) tmp_q  <= mem_rdata;
      if (st == ST_EXEC) begin
        case (op_q)
          OP_SEM: p_q[FLAG_T] <= 1'b1;
          OP_CLM: p_q[FLAG_T] <= 1'b0;
          OP_SEC: p_q[FLAG_C] <= 1'b1;
          OP_CLC: p_q[FLAG_C] <= 1'b0;
          default: begin
            p_q[FLAG_N] <= alu_val[DW-1];
            p_q[FLAG_Z] <= (alu_val == '0);
            if (sets_carry(op_q)) p_q[FLAG_C] <= alu_c;
            if (op_q == OP_LDX)                    x_q   <= alu_val;
            else if (is_rmw(op_q) || use_mem)      res_q <= alu_val;
            else if (op_q != OP_CMP)               acc_q <= alu_val;
          end
        endcase
      end
    end
  end

  always_comb begin
    mem_addr  = addr_q;
    mem_we    = 1'b0;
    mem_wdata = acc_q;
    case (st)
      ST_ISSUE: mem_we = (op_q == OP_STA);
      ST_PTR:   mem_addr = x_addr;
      ST_WBOLD: begin mem_we = 1'b1; mem_wdata = opnd_q; end
      ST_WB:    begin
        mem_we    = 1'b1;
        mem_wdata = res_q;
        mem_addr  = is_rmw(op_q) ? addr_q : x_addr;
      end
      default: ;
    endcase
  end

  assign busy   = (st != ST_IDLE);
  assign acc    = acc_q;
  assign xidx   = x_q;
  assign status = p_q;

  assert_rmw_same_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB && is_rmw(op_q)) |-> (mem_addr == $past(mem_addr, 4)));
  assert_mode_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WB && !is_rmw(op_q)) |-> $stable(acc_q));
  assert_cmp_keeps_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXEC && op_q == OP_CMP) |=> $stable(acc_q));
  assert_write_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

// File: tb/sim_acc_exec_unit.sv
`timescale 1ns/1ps
module sim_acc_exec_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] op_code;
  logic [7:0] op_addr;
  logic       busy, done, mem_we;
  logic [7:0] acc, xidx, status, mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  acc_exec_unit u0 (
    .clk, .rst_n, .start, .op_code, .op_addr, .busy, .done,
    .acc, .xidx, .status, .mem_addr, .mem_we, .mem_wdata, .mem_rdata
  );

  logic [7:0] mem [0:255];
  logic       poke_en = 1'b0;
  logic [7:0] poke_a = '0, poke_d = '0;
  int         wr_cnt = 0;
  logic [7:0] wr_prev = '0, wr_last = '0;

  always @(posedge clk) begin
    if (poke_en)      mem[poke_a] <= poke_d;
    else if (mem_we)  mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mem_we) begin
      wr_cnt  <= wr_cnt + 1;
      wr_prev <= wr_last;
      wr_last <= mem_wdata;
    end
  end

  int checks = 0, fails = 0;

  // {op, addr, expected acc, expected status, expected busy cycles}
  localparam logic [31:0] VEC [0:15] = '{
    32'h0_10_3C_00_3, 32'h1_11_FC_80_3, 32'h2_12_0C_00_3, 32'h3_12_03_00_3,
    32'hE_00_03_01_1, 32'h4_14_03_01_3, 32'hF_00_03_00_1, 32'h4_13_04_00_3,
    32'h5_13_02_01_3, 32'h5_14_03_00_3, 32'h6_13_03_01_3, 32'h6_15_03_80_3,
    32'h0_16_00_02_3, 32'hB_00_00_02_1, 32'h0_15_80_80_3, 32'hB_00_00_03_1
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic run(logic [3:0] op, logic [7:0] a, bit intrude, output int cyc);
    int guard;
    @(negedge clk);
    op_code = op; op_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; guard = 0;
    while (!done) begin
      if (busy) cyc++;
      if (intrude && guard == 0) begin
        start = 1'b1; op_code = 4'h0; op_addr = 8'h16;
      end else begin
        start = 1'b0;
      end
      guard++;
      if (guard > 60) begin
        fails++;
        $display("FAIL R10: operation %0h never completed, got busy expected done", op);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc, w0;
    logic [31:0] v;
    rst_n = 1'b0; start = 1'b0; op_code = '0; op_addr = '0;
    poke(8'h10, 8'h3C); poke(8'h11, 8'hF0); poke(8'h12, 8'h0F);
    poke(8'h13, 8'h01); poke(8'h14, 8'hFF); poke(8'h15, 8'h80);
    poke(8'h16, 8'h00); poke(8'h17, 8'h30); poke(8'h18, 8'hFF);
    poke(8'h30, 8'h05);
    @(negedge clk);
    chk("R1 acc", acc, 0);     chk("R1 xidx", xidx, 0);
    chk("R1 status", status, 0); chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);   chk("R1 mem_we", mem_we, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R11 table walk in normal mode
    for (int i = 0; i < 16; i++) begin
      v = VEC[i];
      run(v[31:28], v[27:20], 1'b0, cyc);
      chk("R2/R3 acc", acc, v[19:12]);
      chk("R4/R11 status", status, v[11:4]);
      chk("R2/R11 cycles", cyc, v[3:0]);
      chk("R10 done pulse", done, 1);
    end

    run(4'h0, 8'h10, 1'b0, cyc);
    chk("R2 lda", acc, 8'h3C);
    run(4'h7, 8'h20, 1'b0, cyc);
    chk("R5 sta cycles", cyc, 1); chk("R5 sta data", mem[8'h20], 8'h3C);
    run(4'h8, 8'h17, 1'b0, cyc);
    chk("R8 ldx", xidx, 8'h30); chk("R8 ldx cycles", cyc, 3);

    w0 = wr_cnt;
    run(4'h9, 8'h18, 1'b1, cyc);
    chk("R9 inc cycles", cyc, 5); chk("R9 inc value", mem[8'h18], 8'h00);
    chk("R9 write count", wr_cnt - w0, 2);
    chk("R9 first write old", wr_prev, 8'hFF); chk("R9 second write new", wr_last, 8'h00);
    chk("R4 inc zero", status[1], 1);
    repeat (3) @(negedge clk);
    chk("R10 start ignored acc", acc, 8'h3C); chk("R10 idle after", busy, 0);
    run(4'hA, 8'h18, 1'b0, cyc);
    chk("R9 dec value", mem[8'h18], 8'hFF); chk("R9 dec cycles", cyc, 5);
    chk("R4 dec neg", status[7], 1);

    run(4'hF, 8'h00, 1'b0, cyc);
    run(4'hC, 8'h00, 1'b0, cyc);
    chk("R11 mode set", status[5], 1); chk("R11 sem cycles", cyc, 1);
    run(4'h1, 8'h12, 1'b0, cyc);
    chk("R6 ora mem", mem[8'h30], 8'h0F); chk("R6 acc kept", acc, 8'h3C);
    chk("R7 ora cycles", cyc, 6);
    run(4'h4, 8'h13, 1'b0, cyc);
    chk("R6 adc mem", mem[8'h30], 8'h10); chk("R3 adc carry", status[0], 0);
    chk("R7 adc cycles", cyc, 6);
    run(4'h6, 8'h11, 1'b0, cyc);
    chk("R7 cmp cycles", cyc, 4); chk("R6 cmp mem kept", mem[8'h30], 8'h10);
    chk("R3 cmp carry", status[0], 0); chk("R6 cmp acc", acc, 8'h3C);
    run(4'h0, 8'h15, 1'b0, cyc);
    chk("R7 lda cycles", cyc, 5); chk("R6 lda mem", mem[8'h30], 8'h80);
    chk("R6 lda acc kept", acc, 8'h3C); chk("R6 lda flag N", status[7], 1);
    run(4'h7, 8'h21, 1'b0, cyc);
    chk("R8 sta in mode", mem[8'h21], 8'h3C); chk("R8 sta cycles", cyc, 1);
    chk("R8 sta x-byte kept", mem[8'h30], 8'h80);
    run(4'hB, 8'h00, 1'b0, cyc);
    chk("R8 asl in mode", acc, 8'h78); chk("R8 asl carry", status[0], 0);
    run(4'h8, 8'h12, 1'b0, cyc);
    chk("R8 ldx in mode", xidx, 8'h0F); chk("R8 ldx x-byte kept", mem[8'h30], 8'h80);
    run(4'hD, 8'h00, 1'b0, cyc);
    chk("R11 mode cleared", status[5], 0);
    run(4'h0, 8'h12, 1'b0, cyc);
    chk("R2 normal again", acc, 8'h0F); chk("R2 normal cycles", cyc, 3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule